// File: doc/BRIEF.md
# DRAM Write Strobe Framer

This block produces the strobe framing around DRAM write bursts. A memory controller raises write enable for as many clocks as a burst carries data. A fixed number of clocks later, the block runs a programmable preamble and then marks the data clocks. If the block generates the CRC itself, it appends a CRC clock. It then closes the burst with a postamble, or it bridges to the next burst with an interamble. The strobe leaves the block as a two-phase value per clock: the first phase is bit 1 and the second is bit 0.

The choice at the end of a burst follows the idle time between writes. A gap counter measures how many clocks write enable stayed low before the next write, and holds that value in a register. When that gap, less any CRC clock, leaves too little room for a postamble followed by a full preamble, the block sends part of a programmable interamble pattern instead. The length of that part equals the idle time. When the idle time is zero, the next data follows at once. Postamble and interamble share one down-counter, since they never occur together.

The controller keeps two rules. Successive rises of write enable come at least the write latency apart. The low gap is at least the number of CRC clocks when CRC is enabled. The burst-length and CRC selects are held steady while a burst is in flight.

Top module: `dqs_write_framer`

## Requirements
- R1: After a synchronous reset, the outputs are at rest: state_o is 0 (idle), strobe_o is 2'b00, and data_o, crc_o and done_o are low.
- R2: data_o goes high 6 clock edges after the edge that first samples wr_en_i high. It stays high for 8 clocks when bl16_i is 1 and for 4 clocks when it is 0. state_o is 2 and strobe_o is 2'b10 in every data clock.
- R3: A burst that does not follow an interamble gets a 3-clock preamble in the 3 clocks just before its data. state_o is 1, and strobe_o shows the pairs of pre_pat_i in order, starting with bits [5:4].
- R4: With crc_en_i at 1, exactly one clock follows the data in which crc_o is high, state_o is 3 and strobe_o is 2'b10. With crc_en_i at 0, no such clock occurs.
- R5: Let G be the number of low clocks between two writes, and let k be G minus 1 if CRC is on, or G otherwise. If 1 <= k <= 4, the k clocks after the first burst are interamble clocks with state_o 4. strobe_o shows the last k pairs of ia_pat_i in order, ending with bits [1:0]. No preamble is sent.
- R6: When k is 0, the second burst's data begins in the clock right after the first burst's last data or CRC clock.
- R7: When no write follows closely (k >= 5 or no second write), the 2 clocks after the burst carry post_pat_i pairs starting with bits [3:2], with state_o 5. After that, strobe_o is 2'b00 and state_o is 0 until the next preamble.
- R8: done_o is high for exactly one clock: the clock after each burst's last data or CRC clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Write enable, high for the data clocks of a burst |
| bl16_i | input | 1 | 1 selects 16-beat bursts, 0 selects 8-beat bursts |
| crc_en_i | input | 1 | 1 appends a CRC clock generated on this side |
| pre_pat_i | input | 2*PRE_CLKS | Preamble pattern, first clock in the top pair |
| post_pat_i | input | 2*POST_CLKS | Postamble pattern, first clock in the top pair |
| ia_pat_i | input | 2*(PRE_CLKS+POST_CLKS-1) | Interamble pattern; its tail is used |
| strobe_o | output | 2 | Strobe value for the two phases of the clock |
| data_o | output | 1 | Data clock flag |
| crc_o | output | 1 | CRC clock flag |
| state_o | output | 3 | Sequencer state (0 idle, 1 preamble, 2 data, 3 CRC, 4 interamble, 5 postamble) |
| done_o | output | 1 | One-clock pulse after a burst completes |

## Verification
Every output comes from a register. A write whose enable is first sampled at edge x has its preamble after edges x+3 to x+5 and its data after edges x+6 onward. Its CRC, done pulse and postamble or interamble follow, each at a clock offset that is fixed by burst length, CRC mode and the gap. The bench builds a per-edge table of strobe, flags, state and done from these offsets for each scenario. It then compares all five outputs in the half clock after every edge, so any output that is off by one clock is caught. Scenarios cover both burst lengths, CRC on and off, single bursts, and every legal gap up to 8. This includes the seamless case and each interamble length.

// File: rtl/dqs_framer_pkg.sv
package dqs_framer_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_PRE  = 3'd1,
    ST_DATA = 3'd2,
    ST_CRC  = 3'd3,
    ST_IAMB = 3'd4,
    ST_POST = 3'd5
  } framer_state_e;
endpackage

// File: rtl/dqs_gap_meter.sv
// Detects the launch of a write and measures the preceding idle time.
module dqs_gap_meter #(
  parameter int GW = 4
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          wr_en_i,
  output logic          rise_o,
  output logic [GW-1:0] gap_o
);
  logic          wr_q;
  logic [GW-1:0] cnt_q;
  logic [GW-1:0] gap_q;

  assign rise_o = wr_en_i & ~wr_q;
  assign gap_o  = gap_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      wr_q  <= 1'b0;
      cnt_q <= '0;
      gap_q <= '0;
    end else begin
      wr_q <= wr_en_i;
      if (wr_en_i) cnt_q <= '0;
      else if (cnt_q != '1) cnt_q <= cnt_q + GW'(1);
      if (rise_o) gap_q <= cnt_q;
    end
  end
endmodule

// File: rtl/dqs_pre_timer.sv
// Counts from the launch of a write to its preamble and data start.
module dqs_pre_timer #(
  parameter int LAT = 6,
  parameter int PRE = 3,
  parameter int CW  = 3
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic rise_i,
  output logic pend_o,
  output logic pre_go_o,
  output logic data_go_o
);
  logic [CW-1:0] cnt_q;
  logic          act_q;

  assign pend_o    = act_q;
  assign pre_go_o  = act_q && (cnt_q == CW'(LAT - PRE));
  assign data_go_o = act_q && (cnt_q == CW'(LAT));

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else if (rise_i) begin
      act_q <= 1'b1;
      cnt_q <= CW'(1);
    end else if (data_go_o) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else if (act_q) begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  // R2
  launch_spacing_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    rise_i |-> (!act_q || data_go_o));
endmodule

// File: rtl/dqs_frame_fsm.sv
// Sequences preamble, data, CRC, interamble and postamble and shifts the strobe.
module dqs_frame_fsm
  import dqs_framer_pkg::*;
#(
  parameter int PRE    = 3,
  parameter int POST   = 2,
  parameter int IA_N   = 4,
  parameter int B_LONG = 8,
  parameter int B_SHRT = 4,
  parameter int CRC_N  = 1,
  parameter int GW     = 4,
  parameter int SW     = 8
) (
  input  logic            clk_i,
  input  logic            rst_i,
  input  logic            bl16_i,
  input  logic            crc_en_i,
  input  logic [2*PRE-1:0]  pre_pat_i,
  input  logic [2*POST-1:0] post_pat_i,
  input  logic [SW-1:0]   ia_pat_i,
  input  logic [GW-1:0]   gap_i,
  input  logic            pend_i,
  input  logic            pre_go_i,
  input  logic            data_go_i,
  output logic [1:0]      strobe_o,
  output logic            data_o,
  output logic            crc_o,
  output logic [2:0]      state_o,
  output logic            done_o
);
  localparam int DMAX = (B_LONG > CRC_N) ? B_LONG : CRC_N;
  localparam int DW   = $clog2(DMAX + 1);
  localparam int AW   = $clog2(IA_N + 1);
  localparam logic [SW-1:0] DATA_IMG = {2'b10, {(SW-2){1'b0}}};

  framer_state_e state_q, state_d;
  logic [DW-1:0] dcnt_q, dcnt_d;
  logic [AW-1:0] amb_q, amb_d;
  logic [SW-1:0] sh_q, sh_d;
  logic          done_q, done_d;

  logic [DW-1:0] blen;
  logic [GW-1:0] crc_g, k;
  logic          use_ia, fin;
  logic [SW-1:0] pre_img, post_img, ia_img;
  int            ia_shift;

  always_comb begin
    blen     = bl16_i ? DW'(B_LONG) : DW'(B_SHRT);
    crc_g    = crc_en_i ? GW'(CRC_N) : '0;
    k        = gap_i - crc_g;
    use_ia   = pend_i && (k != '0) && (k < GW'(PRE + POST));
    pre_img  = SW'(pre_pat_i) << (SW - 2*PRE);
    post_img = SW'(post_pat_i) << (SW - 2*POST);
    ia_shift = use_ia ? 2*(IA_N - int'(k)) : 0;
    ia_img   = ia_pat_i << ia_shift;
  end

  always_comb begin
    state_d = state_q;
    dcnt_d  = dcnt_q;
    amb_d   = amb_q;
    sh_d    = {sh_q[SW-3:0], 2'b00};
    done_d  = 1'b0;
    fin     = 1'b0;
    case (state_q)
      ST_IDLE: if (pre_go_i) begin
        state_d = ST_PRE;
        sh_d    = pre_img;
      end
      ST_PRE: if (data_go_i) begin
        state_d = ST_DATA;
        dcnt_d  = DW'(1);
        sh_d    = DATA_IMG;
      end
      ST_DATA: begin
        sh_d = DATA_IMG;
        if (dcnt_q == blen) begin
          if (crc_en_i) begin
            state_d = ST_CRC;
            dcnt_d  = DW'(1);
          end else begin
            fin = 1'b1;
          end
        end else begin
          dcnt_d = dcnt_q + DW'(1);
        end
      end
      ST_CRC: begin
        sh_d = DATA_IMG;
        if (dcnt_q == DW'(CRC_N)) fin = 1'b1;
        else dcnt_d = dcnt_q + DW'(1);
      end
      ST_IAMB: begin
        amb_d = amb_q - AW'(1);
        if (data_go_i) begin
          state_d = ST_DATA;
          dcnt_d  = DW'(1);
          sh_d    = DATA_IMG;
        end
      end
      ST_POST: begin
        amb_d = amb_q - AW'(1);
        if (amb_q == AW'(1)) begin
          if (pre_go_i) begin
            state_d = ST_PRE;
            sh_d    = pre_img;
          end else begin
            state_d = ST_IDLE;
            sh_d    = '0;
          end
        end
      end
      default: begin
        state_d = ST_IDLE;
        sh_d    = '0;
      end
    endcase
    if (fin) begin
      done_d = 1'b1;
      if (data_go_i) begin
        state_d = ST_DATA;
        dcnt_d  = DW'(1);
        sh_d    = DATA_IMG;
      end else if (use_ia) begin
        state_d = ST_IAMB;
        amb_d   = k[AW-1:0];
        sh_d    = ia_img;
      end else begin
        state_d = ST_POST;
        amb_d   = AW'(POST);
        sh_d    = post_img;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      state_q <= ST_IDLE;
      dcnt_q  <= '0;
      amb_q   <= '0;
      sh_q    <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      dcnt_q  <= dcnt_d;
      amb_q   <= amb_d;
      sh_q    <= sh_d;
      done_q  <= done_d;
    end
  end

  assign strobe_o = sh_q[SW-1 -: 2];
  assign data_o   = (state_q == ST_DATA);
  assign crc_o    = (state_q == ST_CRC);
  assign state_o  = state_q;
  assign done_o   = done_q;

  // R2
  data_entry_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(state_q == ST_DATA) |-> $past(data_go_i));
  // R3
  pre_entry_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(state_q == ST_PRE) |-> $past(pre_go_i));
  // R4
  crc_gate_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (state_q == ST_CRC) |-> crc_en_i);
  // R5
  ia_exit_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (state_q == ST_IAMB) |-> (data_go_i == (amb_q == AW'(1))));
  // R7
  post_len_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (state_q == ST_POST) |-> (amb_q != '0 && amb_q <= AW'(POST)));
  // R8
  done_single_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    done_q |=> !done_q);
endmodule

// File: rtl/dqs_write_framer.sv
module dqs_write_framer #(
  parameter int LAT_CLKS   = 6,
  parameter int PRE_CLKS   = 3,
  parameter int POST_CLKS  = 2,
  parameter int BL_LONG    = 16,
  parameter int BL_SHORT   = 8,
  parameter int BEATS_CLK  = 2,
  parameter int CRC_CLKS   = 1,
  localparam int IA_N      = PRE_CLKS + POST_CLKS - 1,
  localparam int SW        = 2 * IA_N
) (
  input  logic                   clk_i,
  input  logic                   rst_i,
  input  logic                   wr_en_i,
  input  logic                   bl16_i,
  input  logic                   crc_en_i,
  input  logic [2*PRE_CLKS-1:0]  pre_pat_i,
  input  logic [2*POST_CLKS-1:0] post_pat_i,
  input  logic [SW-1:0]          ia_pat_i,
  output logic [1:0]             strobe_o,
  output logic                   data_o,
  output logic                   crc_o,
  output logic [2:0]             state_o,
  output logic                   done_o
);
  localparam int B_LONG = BL_LONG / BEATS_CLK;
  localparam int B_SHRT = BL_SHORT / BEATS_CLK;
  localparam int CW     = $clog2(LAT_CLKS + 1);
  localparam int GW     = $clog2(PRE_CLKS + POST_CLKS + CRC_CLKS + 1) + 1;

  logic          rise;
  logic [GW-1:0] gap;
  logic          pend, pre_go, data_go;

  dqs_gap_meter #(.GW(GW)) u_gap (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .wr_en_i (wr_en_i),
    .rise_o  (rise),
    .gap_o   (gap)
  );

  dqs_pre_timer #(.LAT(LAT_CLKS), .PRE(PRE_CLKS), .CW(CW)) u_timer (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .rise_i    (rise),
    .pend_o    (pend),
    .pre_go_o  (pre_go),
    .data_go_o (data_go)
  );

  dqs_frame_fsm #(
    .PRE(PRE_CLKS), .POST(POST_CLKS), .IA_N(IA_N), .B_LONG(B_LONG),
    .B_SHRT(B_SHRT), .CRC_N(CRC_CLKS), .GW(GW), .SW(SW)
  ) u_fsm (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .bl16_i     (bl16_i),
    .crc_en_i   (crc_en_i),
    .pre_pat_i  (pre_pat_i),
    .post_pat_i (post_pat_i),
    .ia_pat_i   (ia_pat_i),
    .gap_i      (gap),
    .pend_i     (pend),
    .pre_go_i   (pre_go),
    .data_go_i  (data_go),
    .strobe_o   (strobe_o),
    .data_o     (data_o),
    .crc_o      (crc_o),
    .state_o    (state_o),
    .done_o     (done_o)
  );
endmodule

// File: tb/test_dqs_write_framer.sv
module test_dqs_write_framer;
  localparam int CLK_PERIOD = 10;
  localparam int LAT = 6;
  localparam int PRE = 3;
  localparam int POST = 2;
  localparam int IAN = 4;
  localparam int NWIN = 64;
  localparam logic [5:0] PRE_PAT  = 6'b000110;
  localparam logic [3:0] POST_PAT = 4'b1000;
  localparam logic [7:0] IA_PAT   = 8'b01110010;

  logic clk = 1'b0;
  logic rst, wr_en, bl16, crc_en;
  logic [1:0] strobe;
  logic data, crc, done;
  logic [2:0] state;

  int vectors = 0;
  int miscompares = 0;
  logic [1:0] es [NWIN];
  int est [NWIN];
  bit edn [NWIN];

  always #(CLK_PERIOD/2) clk = ~clk;

  dqs_write_framer i_dqs_write_framer (
    .clk_i(clk), .rst_i(rst), .wr_en_i(wr_en), .bl16_i(bl16), .crc_en_i(crc_en),
    .pre_pat_i(PRE_PAT), .post_pat_i(POST_PAT), .ia_pat_i(IA_PAT),
    .strobe_o(strobe), .data_o(data), .crc_o(crc), .state_o(state), .done_o(done)
  );

  task automatic compare(input int t, input string req, input logic [1:0] xs,
                         input int xst, input bit xd);
    logic xdata, xcrc;
    xdata = (xst == 2);
    xcrc  = (xst == 3);
    vectors++;
    if (strobe !== xs || data !== xdata || crc !== xcrc || state !== 3'(xst) || done !== xd) begin
      miscompares++;
      $display("FAIL %s t=%0d: strobe=%b data=%b crc=%b state=%0d done=%b expected strobe=%b data=%b crc=%b state=%0d done=%b",
               req, t, strobe, data, crc, state, done, xs, xdata, xcrc, xst, xd);
    end
  endtask

  task automatic put_pre(input int x);
    for (int j = 0; j < PRE; j++) begin
      est[x+LAT-PRE+j] = 1;
      es[x+LAT-PRE+j]  = PRE_PAT[2*PRE-1-2*j -: 2];
    end
  endtask

  task automatic put_burst(input int x, input int b, input int c);
    for (int j = 0; j < b + c; j++) begin
      est[x+LAT+j] = (j < b) ? 2 : 3;
      es[x+LAT+j]  = 2'b10;
    end
    edn[x+LAT+b+c] = 1'b1;
  endtask

  task automatic put_post(input int e);
    for (int j = 0; j < POST; j++) begin
      est[e+j] = 5;
      es[e+j]  = POST_PAT[2*POST-1-2*j -: 2];
    end
  endtask

  task automatic run_case(input bit bl, input bit cen, input bit two, input int g);
    int b, c, x1, x2, e1, k;
    string req;
    b = bl ? 8 : 4;
    c = cen ? 1 : 0;
    x1 = 1;
    x2 = x1 + b + g;
    e1 = x1 + LAT + b + c;
    k = g - c;
    for (int i = 0; i < NWIN; i++) begin
      es[i] = 2'b00; est[i] = 0; edn[i] = 1'b0;
    end
    put_pre(x1);
    put_burst(x1, b, c);
    if (!two) begin
      put_post(e1);
    end else begin
      if (k >= 1 && k < PRE + POST) begin
        for (int j = 0; j < k; j++) begin
          est[e1+j] = 4;
          es[e1+j]  = IA_PAT[2*IAN-1-2*(IAN-k+j) -: 2];
        end
      end else if (k >= PRE + POST) begin
        put_post(e1);
        put_pre(x2);
      end
      put_burst(x2, b, c);
      put_post(x2 + LAT + b + c);
    end
    bl16 = bl;
    crc_en = cen;
    for (int t = 0; t < NWIN; t++) begin
      @(negedge clk);
      if (edn[t] !== done) req = "R8";
      else if (est[t] == 2 && two && k == 0) req = "R6";
      else if (est[t] == 1) req = "R3";
      else if (est[t] == 2) req = "R2";
      else if (est[t] == 3 || (cen == 1'b0 && crc !== 1'b0)) req = "R4";
      else if (est[t] == 4) req = "R5";
      else req = "R7";
      compare(t, req, es[t], est[t], edn[t]);
      wr_en = ((t + 1 >= x1) && (t + 1 < x1 + b)) ||
              (two && (t + 1 >= x2) && (t + 1 < x2 + b));
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    miscompares++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    rst = 1'b1; wr_en = 1'b0; bl16 = 1'b1; crc_en = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare(0, "R1", 2'b00, 0, 1'b0);
    rst = 1'b0;
    for (int bl = 0; bl < 2; bl++) begin
      for (int cen = 0; cen < 2; cen++) begin
        int gmin;
        run_case(bl[0], cen[0], 1'b0, 0);
        gmin = (bl == 1) ? 1 : 2;
        if (gmin < cen) gmin = cen;
        for (int g = gmin; g <= 8; g++) run_case(bl[0], cen[0], 1'b1, g);
      end
    end
    // R1: reset in the middle of a burst returns everything to rest
    bl16 = 1'b1; crc_en = 1'b1;
    @(negedge clk); wr_en = 1'b1;
    repeat (8) @(negedge clk);
    rst = 1'b1; wr_en = 1'b0;
    repeat (2) @(negedge clk);
    compare(0, "R1", 2'b00, 0, 1'b0);
    rst = 1'b0;
    repeat (10) @(negedge clk);
    compare(1, "R1", 2'b00, 0, 1'b0);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule